// File: doc/BRIEF.md
# Buffered Serial Transmitter with Fractional Bit Timing

This block drives one output line with asynchronous serial frames. Software programs it through three writes: a mode byte that picks the transmit function and enables the output driver, a configuration word that packs the bit period and the data length together, and a data word. The data word lands in a one-entry holding buffer. A shifter takes the buffered word as soon as it is free.

The bit period is a fixed-point count of clock cycles with six fractional bits. A phase accumulator spreads the fraction over the frame, so rates that do not divide the clock evenly still keep their average bit time. Two flags separate the states software cares about. `full_o` shows that a word is waiting in the buffer. The busy bit in `result_o` shows that a frame is on the line. Software therefore never has to send a dummy character to get the flags into a known state.

Clearing `enable_i` holds the transmitter in reset with the line idle. Any mode or configuration write does the same. The mode and configuration values already written are kept.

Top module: `uart_txf_top`

## Requirements
- R1: After `rst_ni` is released, `tx_o` is 1, `full_o` is 0, `result_o` is 0 and `tx_oe_o` is 0.
- R2: The configuration word gives the data length in bits [4:0] as bits minus one, so 7 means 8 bits. It gives the period P in bits [31:10] in units of 1/64 clock cycle.
- R3: A frame has one low start bit, then the data bits LSB first, then one high stop bit. The line is high whenever no frame is being sent.
- R4: Bit k of a frame (start = 0) begins floor... precisely: counting clock edges c after the edge that loads the frame, the line shows bit floor(64·c/P) of the frame. A P below 64 is treated as 64.
- R5: A data write at an edge sets `full_o` after that edge. If the shifter is idle, the next edge moves the word into the shifter, clears `full_o` and sets busy (`result_o[0]`) with the line low.
- R6: When the stop bit ends and the buffer is full, the next frame's start bit begins at that same edge. Busy stays high and the line has no idle gap.
- R7: A data write while the buffer is full, and not being emptied at that edge, is ignored. The buffered word is unchanged.
- R8: A mode or configuration write, or `enable_i` low, aborts any frame and empties the buffer at that edge: `tx_o` is 1, `full_o` is 0 and busy is 0.
- R9: The transmitter runs only when mode bits [5:1] equal 5'b11110. In any other mode, data writes are ignored and the line stays high.
- R10: `tx_oe_o` follows mode bit 0 as last written.
- R11: `result_o[0]` is the busy flag and `result_o[31:1]` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Run enable; low holds the transmitter in reset |
| mode_we_i | input | 1 | Mode write strobe |
| mode_i | input | 8 | Mode byte: bit 0 drive enable, bits [5:1] function |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_i | input | 32 | Configuration word: length in [4:0], period in [31:10] |
| data_we_i | input | 1 | Data write strobe |
| data_i | input | 32 | Data word, sent LSB first |
| tx_o | output | 1 | Serial line |
| tx_oe_o | output | 1 | Output driver enable |
| full_o | output | 1 | Holding buffer holds an untaken word |
| result_o | output | 32 | Bit 0 busy, other bits zero |

## Verification
A data write shows up on `full_o` one edge later. With the shifter idle, the start bit and busy follow one edge after that. Within a frame, every line change falls on the edge where floor(64·c/P) steps up, and an abort takes effect at the edge of the write. The bench model advances one step per rising edge, using the same inputs the design sees, and computes the line from that closed-form bit index. It compares every output 2 ns after each edge, so each result is checked in the cycle it is due and never before.

// File: rtl/uart_txf_pkg.sv
package uart_txf_pkg;
  localparam int DATA_W  = 32;
  localparam int LEN_W   = 5;
  localparam int PER_LSB = 10;
  localparam int PER_W   = 22;
  localparam int MODE_W  = 8;
  localparam int FRAC_W  = 6;
  localparam logic [4:0] MODE_ASYNC_TX = 5'b11110;

  typedef struct packed {
    logic [PER_W-1:0] per;
    logic [LEN_W-1:0] len;
  } cfg_t;

  function automatic cfg_t unpack_cfg(input logic [31:0] w);
    cfg_t c;
    c.per = w[PER_LSB +: PER_W];
    c.len = w[LEN_W-1:0];
    return c;
  endfunction
endpackage

// File: rtl/uart_txf_phase.sv
module uart_txf_phase #(
  parameter int PER_W  = 22,
  parameter int FRAC_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             restart_i,
  input  logic             run_i,
  input  logic [PER_W-1:0] per_i,
  output logic             tick_o
);
  localparam logic [PER_W:0] ONE = (PER_W+1)'(1) << FRAC_W;

  logic [PER_W-1:0] acc_q;
  logic [PER_W:0]   per_eff, sum;

  // clamp to at least one cycle per bit
  assign per_eff = ({1'b0, per_i} < ONE) ? ONE : {1'b0, per_i};
  assign sum     = {1'b0, acc_q} + ONE;
  assign tick_o  = run_i && (sum >= per_eff);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                acc_q <= '0;
    else if (clr_i || restart_i) acc_q <= '0;
    else if (run_i)             acc_q <= tick_o ? PER_W'(sum - per_eff) : PER_W'(sum);
  end

  assert_acc_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {1'b0, acc_q} < per_eff);
endmodule

// File: rtl/uart_txf_hold.sv
module uart_txf_hold #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              take_i,
  output logic              full_o,
  output logic [DATA_W-1:0] data_o
);
  logic              full_q;
  logic [DATA_W-1:0] buf_q;
  logic              accept;

  assign accept = wr_i && (!full_q || take_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      buf_q  <= '0;
    end else if (clr_i) begin
      full_q <= 1'b0;
    end else if (accept) begin
      full_q <= 1'b1;
      buf_q  <= wdata_i;
    end else if (take_i) begin
      full_q <= 1'b0;
    end
  end

  assign full_o = full_q;
  assign data_o = buf_q;

  assert_full_after_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !clr_i) |=> full_q);
  assert_ignore_when_full_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_q && wr_i && !take_i && !clr_i) |=> $stable(buf_q));
endmodule

// File: rtl/uart_txf_shift.sv
module uart_txf_shift #(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              tick_i,
  input  logic              full_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic              take_o,
  output logic              end_o,
  output logic              busy_o,
  output logic              line_o
);
  localparam int IDX_W = $clog2(DATA_W + 3);

  logic              busy_q, line_q;
  logic [IDX_W-1:0]  idx_q, stop_idx, idx_nxt;
  logic [DATA_W-1:0] sh_q;

  assign stop_idx = IDX_W'(len_i) + IDX_W'(2);
  assign idx_nxt  = idx_q + IDX_W'(1);
  assign end_o    = busy_q && tick_i && (idx_q == stop_idx);
  assign take_o   = full_i && (!busy_q || end_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      line_q <= 1'b1;
      idx_q  <= '0;
      sh_q   <= '0;
    end else if (clr_i) begin
      busy_q <= 1'b0;
      line_q <= 1'b1;
      idx_q  <= '0;
    end else if (take_o) begin
      busy_q <= 1'b1;
      line_q <= 1'b0;
      idx_q  <= '0;
      sh_q   <= data_i;
    end else if (end_o) begin
      busy_q <= 1'b0;
      line_q <= 1'b1;
    end else if (busy_q && tick_i) begin
      idx_q <= idx_nxt;
      if (idx_nxt == stop_idx) begin
        line_q <= 1'b1;
      end else begin
        line_q <= sh_q[0];
        sh_q   <= sh_q >> 1;
      end
    end
  end

  assign busy_o = busy_q;
  assign line_o = line_q;

  assert_idle_high_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> line_q);
  assert_start_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> !line_q);
endmodule

// File: rtl/uart_txf_top.sv
module uart_txf_top
  import uart_txf_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          enable_i,
  input  logic          mode_we_i,
  input  logic [7:0]    mode_i,
  input  logic          cfg_we_i,
  input  logic [31:0]   cfg_i,
  input  logic          data_we_i,
  input  logic [DW-1:0] data_i,
  output logic          tx_o,
  output logic          tx_oe_o,
  output logic          full_o,
  output logic [31:0]   result_o
);
  logic [MODE_W-1:0] mode_q;
  logic [31:0]       cfg_q;
  cfg_t              cfg;
  logic              run, clr, tick, take, stop_end, busy, full;
  logic [DW-1:0]     buf_data;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      cfg_q  <= '0;
    end else begin
      if (mode_we_i) mode_q <= mode_i;
      if (cfg_we_i)  cfg_q  <= cfg_i;
    end
  end

  assign cfg = unpack_cfg(cfg_q);
  assign run = enable_i && (mode_q[5:1] == MODE_ASYNC_TX);
  assign clr = !run || cfg_we_i || mode_we_i;

  uart_txf_phase #(.PER_W(PER_W), .FRAC_W(FRAC_W)) u_phase (
    .clk_i, .rst_ni, .clr_i(clr), .restart_i(take), .run_i(busy),
    .per_i(cfg.per), .tick_o(tick)
  );

  uart_txf_hold #(.DATA_W(DW)) u_hold (
    .clk_i, .rst_ni, .clr_i(clr), .wr_i(data_we_i), .wdata_i(data_i),
    .take_i(take), .full_o(full), .data_o(buf_data)
  );

  uart_txf_shift #(.DATA_W(DW), .LEN_W(LEN_W)) u_shift (
    .clk_i, .rst_ni, .clr_i(clr), .tick_i(tick), .full_i(full),
    .data_i(buf_data), .len_i(cfg.len), .take_o(take), .end_o(stop_end),
    .busy_o(busy), .line_o(tx_o)
  );

  assign tx_oe_o  = mode_q[0];
  assign full_o   = full;
  assign result_o = {31'b0, busy};

  assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i || mode_we_i || !enable_i) |=> (!full_o && !busy && tx_o));
  assert_no_gap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_end && full && !clr) |=> (busy && !tx_o && !full_o));
  assert_handoff_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full && !busy && !clr && !data_we_i) |=> (busy && !full_o));
  assert_wrong_mode_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q[5:1] != MODE_ASYNC_TX) |-> (tx_o && !busy));
endmodule

// File: tb/uart_txf_top_test.sv
module uart_txf_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        mode_we = 1'b0, cfg_we = 1'b0, data_we = 1'b0;
  logic [7:0]  mode_d = '0;
  logic [31:0] cfg_d = '0, data_d = '0;
  logic        tx, tx_oe, full;
  logic [31:0] result;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  uart_txf_top uut (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .mode_we_i(mode_we), .mode_i(mode_d),
    .cfg_we_i(cfg_we), .cfg_i(cfg_d), .data_we_i(data_we), .data_i(data_d),
    .tx_o(tx), .tx_oe_o(tx_oe), .full_o(full), .result_o(result)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference
  bit          m_busy, m_full;
  logic [31:0] m_buf, m_sh, m_cfg;
  logic [7:0]  m_mode;
  longint      m_c;

  function automatic longint per_of();
    longint p = longint'(m_cfg[31:10]);
    return (p < 64) ? 64 : p;
  endfunction

  function automatic int nbits_of();
    return int'(m_cfg[4:0]) + 1;
  endfunction

  function automatic bit exp_line();
    longint k;
    if (!m_busy) return 1'b1;
    k = (m_c * 64) / per_of();
    if (k == 0) return 1'b0;
    if (k <= nbits_of()) return m_sh[int'(k - 1)];
    return 1'b1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_full = 0; m_buf = '0; m_sh = '0; m_cfg = '0; m_mode = '0; m_c = 0;
    end else begin
      bit run, fin, take, acc;
      run = en && (m_mode[5:1] == 5'b11110);
      if (!run || cfg_we || mode_we) begin
        m_busy = 0; m_full = 0;
      end else begin
        fin = 0;
        if (m_busy) begin
          m_c++;
          if ((m_c * 64) / per_of() >= nbits_of() + 2) fin = 1;
        end
        take = m_full && (!m_busy || fin);
        if (take) begin m_sh = m_buf; m_busy = 1; m_c = 0; end
        else if (fin) m_busy = 0;
        acc = data_we && (!m_full || take);
        if (acc) begin m_buf = data_d; m_full = 1; end
        else if (take) m_full = 0;
      end
      if (mode_we) m_mode = mode_d;
      if (cfg_we) m_cfg = cfg_d;
    end
  end

  // compare every cycle, away from the edge
  always @(posedge clk) begin
    #2;
    if (!done) begin
      chk(tx == exp_line(), "R2 R3 R4 R6 R7 R9 tx_o", tx, exp_line());
      chk(full == m_full, "R5 R7 R8 full_o", full, m_full);
      chk(result == {31'b0, m_busy}, "R5 R11 result_o", result, {31'b0, m_busy});
      chk(tx_oe == m_mode[0], "R10 tx_oe_o", tx_oe, m_mode[0]);
    end
  end

  task automatic wmode(input logic [7:0] v);
    @(negedge clk); mode_we = 1; mode_d = v;
    @(negedge clk); mode_we = 0;
  endtask
  task automatic wcfg(input int per, input int len);
    @(negedge clk); cfg_we = 1; cfg_d = (32'(per) << 10) | 32'(len);
    @(negedge clk); cfg_we = 0;
  endtask
  task automatic wdat(input logic [31:0] v);
    @(negedge clk); data_we = 1; data_d = v;
    @(negedge clk); data_we = 0;
  endtask
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(tx == 1 && full == 0 && result == 0 && tx_oe == 0, "R1 reset state",
        {tx, full, result[0], tx_oe}, 4'b1000);

    // configure while disabled, then run: 3.3125 cycles per bit, 8 bits
    wmode(8'h3D);
    wcfg(212, 7);
    en = 1;
    wdat(32'hA5);
    idle(40);

    // back-to-back frames and write-while-full
    wdat(32'h3C);
    idle(2);
    wdat(32'hC3);
    wdat(32'h77);   // R7: buffer full, dropped
    idle(80);

    // one cycle per bit, 5 bits; then clamped period
    wcfg(64, 4);
    wdat(32'h15);
    idle(12);
    wcfg(10, 4);
    wdat(32'h0A);
    wdat(32'h1F);
    idle(20);

    // 32 data bits, 1.5625 cycles per bit
    wcfg(100, 31);
    wdat(32'hDEADBEEF);
    wdat(32'h12345678);
    idle(120);

    // R8: abort by configuration write mid-frame with buffer full
    wcfg(300, 7);
    wdat(32'h55);
    wdat(32'hAA);
    idle(6);
    @(negedge clk); cfg_we = 1; cfg_d = (32'(300) << 10) | 32'd7;
    @(negedge clk); cfg_we = 0;
    chk(full == 0 && tx == 1 && result == 0, "R8 cfg write abort",
        {full, tx, result[0]}, 3'b010);

    // R8: enable low mid-frame
    wdat(32'h81);
    idle(10);
    @(negedge clk); en = 0;
    @(negedge clk);
    chk(full == 0 && tx == 1 && result == 0, "R8 enable low abort",
        {full, tx, result[0]}, 3'b010);
    en = 1;
    wdat(32'h42);
    idle(50);

    // R10: driver off, transmit still works
    wmode(8'h3C);
    wdat(32'h99);
    idle(45);

    // R9: wrong function, writes ignored
    wmode(8'h01);
    wdat(32'hFF);
    @(negedge clk);
    chk(full == 0 && tx == 1, "R9 wrong mode ignores data", {full, tx}, 2'b01);
    idle(10);
    wmode(8'h3D);
    wdat(32'h00);
    idle(45);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule